// File: doc/BRIEF.md
# Pseudo-Random Bit Error Counter

This block measures how often a link corrupts bits. On the send side a 23-bit maximal-length shift-register generator produces a pseudo-random bit stream from a stored seed. On the receive side a second, identical generator is loaded with the same seed and rebuilds the sequence the far end should have sent. Each valid received bit is compared with the rebuilt bit. The block keeps two totals: bits compared and bits that differed. The error ratio is the second total divided by the first.

A run begins with a start pulse. The pulse clears the totals and reloads both generators. Because the receive path adds latency, a programmable number of leading received bits is discarded before comparison begins. Three stop conditions can be enabled in any mix: a bit-count limit, an error-count limit and an elapsed-cycle limit. The first one met ends the run. A done flag is then raised, and a reason code shows which limit or limits fired. The totals stay frozen until the next start. Configuration can only be changed while no run is active.

Top module: `bert_engine`

## Requirements
- R1: The send generator holds state s. Its output bit is s[22]. Each cycle with tx_ready high it steps to {s[21:0], s[22]^s[17]}, which is the polynomial x^23 + x^18 + 1. The receive reference generator uses the same rule.
- R2: A stored seed of zero is replaced by 23'h000001 whenever a generator is loaded.
- R3: A start pulse clears bit_cnt, err_cnt, the cycle count, stop_why and done. It sets busy and loads both generators from the stored seed. After reset, busy, done, stop_why and both totals are zero.
- R4: During a run, the first cfg_skip valid received bits are discarded. They are not counted and the reference generator does not advance on them.
- R5: Every later valid received bit during a run adds one to bit_cnt and advances the reference generator. It adds one to err_cnt when rx_bit differs from the reference output bit.
- R6: With cfg_lim_en[0] set, the run ends at the clock edge where bit_cnt reaches cfg_bit_lim.
- R7: With cfg_lim_en[1] set, the run ends at the clock edge where err_cnt reaches cfg_err_lim.
- R8: With cfg_lim_en[2] set, the run ends at the clock edge where the count of busy cycles reaches cfg_cyc_lim.
- R9: When a run ends, busy drops and done rises. done stays high until the next start. stop_why bit 0 marks the bit limit, bit 1 the error limit and bit 2 the cycle limit. Every limit met on the ending edge has its bit set.
- R10: Once done is high, bit_cnt and err_cnt do not change, whatever arrives on the receive inputs.
- R11: A configuration write (cfg_we) made while busy is high has no effect.
- R12: bit_cnt, err_cnt and the cycle count stop at 2^W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration inputs |
| cfg_seed | input | 23 | Generator seed |
| cfg_skip | input | DW | Number of leading valid received bits to discard |
| cfg_lim_en | input | 3 | Limit enables: bit 0 bits, bit 1 errors, bit 2 cycles |
| cfg_bit_lim | input | W | Bit-count limit |
| cfg_err_lim | input | W | Error-count limit |
| cfg_cyc_lim | input | W | Busy-cycle limit |
| start | input | 1 | Begins a new run |
| tx_ready | input | 1 | Advances the send generator |
| tx_bit | output | 1 | Current send bit |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received bit |
| bit_cnt | output | W | Bits compared |
| err_cnt | output | W | Mismatched bits |
| busy | output | 1 | Run active |
| done | output | 1 | Run ended |
| stop_why | output | 3 | Limits that ended the run |

## Verification
The hardest case to reach from the ports is two limits firing on the same edge. The random stimulus almost never lines them up. A directed run therefore drives valid received bits on every cycle with equal bit and cycle limits, so both limits reach their value on the same edge. Saturation is reached in a bench build with narrow counters, where every bit is inverted and no limit is enabled. Random gaps in tx_ready and rx_valid show that the two generators stay aligned under uneven traffic, and extra traffic sent after each run ends shows that the totals stay frozen.

// File: rtl/bert_engine.sv
module bert_engine #(
  parameter int W  = 48,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [22:0]   cfg_seed,
  input  logic [DW-1:0] cfg_skip,
  input  logic [2:0]    cfg_lim_en,
  input  logic [W-1:0]  cfg_bit_lim,
  input  logic [W-1:0]  cfg_err_lim,
  input  logic [W-1:0]  cfg_cyc_lim,
  input  logic          start,
  input  logic          tx_ready,
  output logic          tx_bit,
  input  logic          rx_valid,
  input  logic          rx_bit,
  output logic [W-1:0]  bit_cnt,
  output logic [W-1:0]  err_cnt,
  output logic          busy,
  output logic          done,
  output logic [2:0]    stop_why
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [22:0] lfsr_step(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  logic [22:0]   seed_q, tx_s, rx_s;
  logic [DW-1:0] skip_q, skip_cnt;
  logic [2:0]    en_q;
  logic [W-1:0]  bit_lim_q, err_lim_q, cyc_lim_q, cyc_cnt;

  wire [22:0]  seed_eff = (seed_q == '0) ? 23'd1 : seed_q;
  wire         skipping = skip_cnt < skip_q;
  wire         cmp      = busy & rx_valid & ~skipping;
  wire         miss     = cmp & (rx_bit != rx_s[22]);
  wire [W-1:0] bit_n    = cmp  ? sat_inc(bit_cnt) : bit_cnt;
  wire [W-1:0] err_n    = miss ? sat_inc(err_cnt) : err_cnt;
  wire [W-1:0] cyc_n    = sat_inc(cyc_cnt);
  wire [2:0]   hit      = en_q & {cyc_n >= cyc_lim_q, err_n >= err_lim_q, bit_n >= bit_lim_q};

  assign tx_bit = tx_s[22];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q    <= '0;
      skip_q    <= '0;
      en_q      <= '0;
      bit_lim_q <= '0;
      err_lim_q <= '0;
      cyc_lim_q <= '0;
    end else if (cfg_we && !busy) begin
      seed_q    <= cfg_seed;
      skip_q    <= cfg_skip;
      en_q      <= cfg_lim_en;
      bit_lim_q <= cfg_bit_lim;
      err_lim_q <= cfg_err_lim;
      cyc_lim_q <= cfg_cyc_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_s <= 23'd1;
    else if (start)    tx_s <= seed_eff;
    else if (tx_ready) tx_s <= lfsr_step(tx_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s     <= 23'd1;
      skip_cnt <= '0;
      bit_cnt  <= '0;
      err_cnt  <= '0;
      cyc_cnt  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      stop_why <= '0;
    end else if (start) begin
      rx_s     <= seed_eff;
      skip_cnt <= '0;
      bit_cnt  <= '0;
      err_cnt  <= '0;
      cyc_cnt  <= '0;
      busy     <= 1'b1;
      done     <= 1'b0;
      stop_why <= '0;
    end else if (busy) begin
      bit_cnt <= bit_n;
      err_cnt <= err_n;
      cyc_cnt <= cyc_n;
      if (rx_valid && skipping) skip_cnt <= skip_cnt + 1'b1;
      if (cmp) rx_s <= lfsr_step(rx_s);
      if (|hit) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        stop_why <= hit;
      end
    end
  end
endmodule

// File: rtl/bert_engine_chk.sv
module bert_engine_chk #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] bit_cnt,
  input logic [W-1:0] err_cnt,
  input logic         busy,
  input logic         done,
  input logic [2:0]   stop_why
);
  localparam logic [W-1:0] TOP = '1;

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bit_cnt == '0 && err_cnt == '0 && busy && !done && stop_why == '0));

  p_err_not_above_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= bit_cnt);

  p_bit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (bit_cnt == $past(bit_cnt) || bit_cnt == $past(bit_cnt) + 1'b1));

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_done_has_reason_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> stop_why != 3'b000);

  p_done_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(stop_why)));

  p_frozen_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(bit_cnt) && $stable(err_cnt)));

  p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == TOP && !start) |=> err_cnt == TOP);
endmodule

bind bert_engine bert_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
  .busy(busy), .done(done), .stop_why(stop_why)
);

// File: tb/bert_engine_tb.sv
`timescale 1ns/1ps
module bert_engine_tb;
  localparam int W  = 10;
  localparam int DW = 8;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, start = 0, tx_ready = 0, rx_valid = 0, rx_bit = 0;
  logic [22:0] cfg_seed = '0;
  logic [DW-1:0] cfg_skip = '0;
  logic [2:0] cfg_lim_en = '0;
  logic [W-1:0] cfg_bit_lim = '0, cfg_err_lim = '0, cfg_cyc_lim = '0;
  logic tx_bit, busy, done;
  logic [W-1:0] bit_cnt, err_cnt;
  logic [2:0] stop_why;

  always #2 clk = ~clk;

  bert_engine #(.W(W), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seed(cfg_seed), .cfg_skip(cfg_skip),
    .cfg_lim_en(cfg_lim_en), .cfg_bit_lim(cfg_bit_lim), .cfg_err_lim(cfg_err_lim),
    .cfg_cyc_lim(cfg_cyc_lim), .start(start), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
    .busy(busy), .done(done), .stop_why(stop_why)
  );

  int checks = 0, errors = 0, tx_bad = 0;
  logic [22:0] m_seed = '0, m_tx = 23'd1, m_rx = 23'd1;
  int m_skip = 0, m_skipc = 0, m_bits = 0, m_errs = 0, m_cyc = 0;
  int m_blim = 0, m_elim = 0, m_clim = 0;
  logic [2:0] m_en = '0, m_why = '0;
  bit m_busy = 0, m_done = 0;

  function automatic logic [22:0] step(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic int sat(input int v);
    return (v > TOPV) ? TOPV : v;
  endfunction

  function automatic logic [22:0] eff_seed(input logic [22:0] s);
    return (s == '0) ? 23'd1 : s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mstep(input bit v, input bit b, input bit tr);
    logic [2:0] hit;
    if (tr) m_tx = step(m_tx);
    if (m_busy) begin
      m_cyc = sat(m_cyc + 1);
      if (v) begin
        if (m_skipc < m_skip) m_skipc++;
        else begin
          m_bits = sat(m_bits + 1);
          if (b != m_rx[22]) m_errs = sat(m_errs + 1);
          m_rx = step(m_rx);
        end
      end
      hit = m_en & {m_cyc >= m_clim, m_errs >= m_elim, m_bits >= m_blim};
      if (hit != 0) begin
        m_busy = 0; m_done = 1; m_why = hit;
      end
    end
  endtask

  task automatic tick(input int vpct, input int fpct, input int tpct);
    bit v, f, tr, b;
    @(negedge clk);
    cfg_we = 0; start = 0;
    if (tx_bit !== m_tx[22]) tx_bad++;
    v  = ($urandom_range(99) < vpct);
    f  = ($urandom_range(99) < fpct);
    tr = ($urandom_range(99) < tpct);
    b  = (m_busy && m_skipc < m_skip) ? ~m_rx[22] : (m_rx[22] ^ f);
    rx_valid = v; rx_bit = b; tx_ready = tr;
    mstep(v, b, tr);
  endtask

  task automatic cfg(input logic [22:0] s, input int sk, input logic [2:0] en,
                     input int bl, input int el, input int cl);
    @(negedge clk);
    start = 0; rx_valid = 0; tx_ready = 0;
    cfg_we = 1; cfg_seed = s; cfg_skip = DW'(sk); cfg_lim_en = en;
    cfg_bit_lim = W'(bl); cfg_err_lim = W'(el); cfg_cyc_lim = W'(cl);
    if (!m_busy) begin
      m_seed = s; m_skip = sk; m_en = en; m_blim = bl; m_elim = el; m_clim = cl;
    end
    mstep(0, 0, 0);
  endtask

  task automatic go();
    @(negedge clk);
    cfg_we = 0; rx_valid = 0; tx_ready = 0; start = 1;
    m_tx = eff_seed(m_seed); m_rx = eff_seed(m_seed);
    m_bits = 0; m_errs = 0; m_cyc = 0; m_skipc = 0;
    m_busy = 1; m_done = 0; m_why = 0;
  endtask

  task automatic check_state(input string req);
    @(negedge clk);
    cfg_we = 0; start = 0; rx_valid = 0; tx_ready = 0;
    check({req, " bit_cnt"}, int'(bit_cnt), m_bits);
    check({req, " err_cnt"}, int'(err_cnt), m_errs);
    check({req, " busy"}, int'(busy), int'(m_busy));
    check({req, " done"}, int'(done), int'(m_done));
    check({req, " stop_why"}, int'(stop_why), int'(m_why));
    mstep(0, 0, 0);
  endtask

  task automatic run(input int n, input int vpct, input int fpct, input int tpct);
    for (int i = 0; i < n && !m_done; i++) tick(vpct, fpct, tpct);
    for (int i = 0; i < 20; i++) tick(100, 50, 50);
  endtask

  task automatic check_tx(input string req);
    check({req, " send bit mismatches"}, tx_bad, 0);
    tx_bad = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    check_state("R3 reset");

    // R6 bit limit, R1 send sequence, R5 counting
    cfg(23'h05A5A5, 0, 3'b001, 300, 0, 0);
    go();
    run(5000, 70, 10, 60);
    check_state("R6 bit limit / R5 / R10");
    check_tx("R1");

    // R7 error limit
    cfg(23'h1F0C3B, 0, 3'b010, 0, 25, 0);
    go();
    run(5000, 60, 20, 40);
    check_state("R7 error limit / R10");
    check_tx("R1");

    // R8 cycle limit
    cfg(23'h2345AB, 0, 3'b100, 0, 0, 400);
    go();
    run(5000, 50, 5, 80);
    check_state("R8 cycle limit / R10");

    // R9 two limits on the same edge
    cfg(23'h0000F1, 0, 3'b101, 64, 0, 64);
    go();
    run(5000, 100, 3, 50);
    check_state("R9 simultaneous limits");
    check("R9 stop_why both bits", int'(stop_why), 3'b101);

    // R4 discarded leading bits (all inverted, must not count)
    cfg(23'h3ABCDE, 7, 3'b001, 150, 0, 0);
    go();
    run(5000, 60, 0, 50);
    check_state("R4 skip");
    check("R4 no errors from skipped bits", int'(err_cnt), 0);

    // R2 zero seed replaced
    cfg(23'h000000, 0, 3'b001, 100, 0, 0);
    go();
    run(5000, 80, 10, 100);
    check_state("R2 zero seed");
    check_tx("R2");

    // R11 writes ignored while busy
    cfg(23'h0BEEF1, 0, 3'b100, 0, 0, 200);
    go();
    for (int i = 0; i < 30; i++) tick(70, 10, 50);
    cfg(23'h7FFFFF, 3, 3'b001, 0, 0, 5);
    run(5000, 70, 10, 50);
    check_state("R11 busy write ignored");
    go();
    for (int i = 0; i < 300; i++) tick(60, 10, 70);
    check_tx("R11 seed kept");
    check_state("R11 limit kept");

    // R12 saturation
    cfg(23'h12345, 0, 3'b000, 0, 0, 0);
    go();
    for (int i = 0; i < 1100; i++) tick(100, 100, 50);
    check_state("R12 saturate");
    check("R12 err_cnt at top", int'(err_cnt), TOPV);

    // R3 restart clears
    go();
    check_state("R3 restart");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule